// File: doc/BRIEF.md
# Microwire Serial Memory Slave

This block is the device side of a three-wire serial memory link with start-bit framing. A controller selects it with `cs`, toggles the serial clock `sk` and shifts commands in on `di`. The block answers on `do_o`, which is qualified by the tri-state enable `do_oe`. Each command is a start bit, an opcode and an address. Write-type commands then carry a data field. The block reads from and writes to a small register array. After a write-type command it is busy for a programmable time, and during that time it reports ready/busy on the data-out line.

The pins `cs`, `sk` and `di` are sampled on the system clock `clk`. Edges of `sk` are found by comparing each sample with the one before, so the serial clock must be much slower than `clk`. The storage is one array of bytes. In 16-bit organization a word is a pair of bytes, and in 8-bit organization each byte is addressed on its own. The `org_x16` input picks the organization.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame starts at the first rising `sk` edge that samples `di`=1 while `cs` is high. Zeros sampled before that edge have no effect.
- R2: The two opcode bits that follow the start bit decode as read=10, write=01 and erase=11. With opcode 00, the two most significant address bits select: 00 disables writing, 01 writes one value to every word, 10 erases every word, 11 enables writing.
- R3: The address field is AW bits when `org_x16`=1 and AW+1 bits when `org_x16`=0. Word a in 16-bit organization is made of byte 2a+1 (high half) and byte 2a (low half) of the same storage that 8-bit organization addresses directly.
- R4: For a read, `do_oe` rises and `do_o` is 0 once the last address bit has been sampled. Each following rising `sk` edge then presents the next data bit, most significant bit first. While `cs` stays high, the read continues into the next address and wraps from the top of the address space to 0.
- R5: A write carries 16 data bits in 16-bit organization and 8 in 8-bit organization, MSB first. The storage changes when `cs` falls after the final data bit.
- R6: Storage holds all ones after reset. Erase sets the addressed word to all ones. Erase-all sets every byte to all ones. Write-all stores the data in every word.
- R7: Writing is disabled after reset. It is enabled by the enable command and disabled again by the disable command. A write or erase received while writing is disabled leaves the storage unchanged and starts no busy period.
- R8: An accepted write-type command is busy for BUSY_CYC `clk` cycles after `cs` falls. While the status is shown with `cs` high, `do_oe`=1 and `do_o`=0 during the busy period, and `do_o`=1 after it ends. Start bits are not accepted while busy.
- R9: While the status is shown, a 1 sampled on a rising `sk` edge keeps `do_oe` high until the next falling `sk` edge, and `do_oe` goes low from then on. The status is not shown again until another write-type command is accepted.
- R10: `do_oe` is low when `cs` is low. It is also low with `cs` high unless a read is in progress or the status is shown.
- R11: Lowering `cs` returns the decoder to waiting for a start bit. A write cut short before its last data bit changes nothing and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| org_x16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Drive enable for `do_o`; low means high impedance |

## Verification
The assertions check, on every cycle, the rules that hold at all times. Deselecting returns the decoder to idle. No frame starts while busy. A busy period starts only when writing is enabled. Read position changes only on rising `sk`. A read opens with a driven 0. The status flag drops only after a falling `sk`. The bench scenarios are the only place where data contents are checked: words read back against an arithmetic model after sweeps of writes, the byte mapping between the two organizations, address wraparound in a long read, the exact length of the busy period, and the effect of commands that were blocked or cut short.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter int AW = 6,
  parameter int BUSY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_x16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);

  localparam int NB  = 2 ** (AW + 1);
  localparam int HW  = AW + 3;
  localparam int CW  = $clog2(HW + 17);
  localparam int BCW = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DAT, S_RD, S_HOLD} st_t;
  typedef enum logic [2:0] {P_NONE, P_WR, P_ER, P_WRAL, P_ERAL} pend_t;

  st_t            st;
  pend_t          pend;
  logic           sk_q, cs_q;
  logic [HW-2:0]  hdr;
  logic [CW-1:0]  cnt;
  logic [AW:0]    adr, rd_adr;
  logic [15:0]    dat;
  logic           wen, wral, stat_arm, stat_clr, rd_dummy;
  logic [3:0]     rd_bit;
  logic [BCW-1:0] busy_cnt;
  logic [7:0]     mem [NB];

  logic sk_rise, sk_fall, cs_fall, busy, hdr_last, dat_last, stat_on, rbit;
  logic [HW-1:0] hdr_nx;
  logic [1:0]    op_nx, sub_nx;
  logic [AW:0]   adr_nx;
  logic [AW-1:0] rd_lo_inc;
  logic [15:0]   wval, rword;

  assign sk_rise  = sk & ~sk_q;
  assign sk_fall  = ~sk & sk_q;
  assign cs_fall  = ~cs & cs_q;
  assign busy     = busy_cnt != '0;
  assign hdr_nx   = {hdr, di};
  assign op_nx    = org_x16 ? hdr_nx[AW+1:AW] : hdr_nx[AW+2:AW+1];
  assign sub_nx   = org_x16 ? hdr_nx[AW-1:AW-2] : hdr_nx[AW:AW-1];
  assign adr_nx   = org_x16 ? {1'b0, hdr_nx[AW-1:0]} : hdr_nx[AW:0];
  assign hdr_last = cnt == CW'(org_x16 ? AW + 1 : AW + 2);
  assign dat_last = cnt == CW'(org_x16 ? 15 : 7);
  assign wval     = (pend == P_WR) ? dat : 16'hFFFF;
  assign rd_lo_inc = rd_adr[AW-1:0] + AW'(1);

  assign rword = org_x16 ? {mem[{rd_adr[AW-1:0], 1'b1}], mem[{rd_adr[AW-1:0], 1'b0}]}
                         : {8'h00, mem[rd_adr]};
  assign rbit  = rword[org_x16 ? 4'd15 - rd_bit : 4'd7 - rd_bit];

  assign stat_on = cs && stat_arm && (st != S_RD);
  assign do_oe   = stat_on || (cs && st == S_RD);
  assign do_o    = do_oe && ((st == S_RD) ? (!rd_dummy && rbit) : !busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pend <= P_NONE;
      sk_q <= 1'b0;
      cs_q <= 1'b0;
      hdr <= '0;
      cnt <= '0;
      adr <= '0;
      rd_adr <= '0;
      dat <= '0;
      wen <= 1'b0;
      wral <= 1'b0;
      stat_arm <= 1'b0;
      stat_clr <= 1'b0;
      rd_dummy <= 1'b0;
      rd_bit <= '0;
      busy_cnt <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
      if (busy) busy_cnt <= busy_cnt - BCW'(1);
      if (!cs) begin
        st <= S_IDLE;
        cnt <= '0;
        stat_clr <= 1'b0;
        pend <= P_NONE;
        if (cs_fall && pend != P_NONE) begin
          case (pend)
            P_WR, P_ER:
              if (org_x16) begin
                mem[{adr[AW-1:0], 1'b1}] <= wval[15:8];
                mem[{adr[AW-1:0], 1'b0}] <= wval[7:0];
              end else begin
                mem[adr] <= wval[7:0];
              end
            default:
              for (int i = 0; i < NB; i++)
                mem[i] <= (pend == P_WRAL) ? ((org_x16 && i[0]) ? dat[15:8] : dat[7:0]) : 8'hFF;
          endcase
          busy_cnt <= BCW'(BUSY_CYC);
          stat_arm <= 1'b1;
        end
      end else begin
        if (sk_fall && stat_clr) begin
          stat_arm <= 1'b0;
          stat_clr <= 1'b0;
        end
        case (st)
          S_IDLE:
            if (sk_rise && di) begin
              if (stat_arm) stat_clr <= 1'b1;
              if (!busy) begin
                st <= S_HDR;
                cnt <= '0;
              end
            end
          S_HDR:
            if (sk_rise) begin
              hdr <= hdr_nx[HW-2:0];
              cnt <= cnt + CW'(1);
              if (hdr_last) begin
                adr <= adr_nx;
                st <= S_HOLD;
                cnt <= '0;
                case (op_nx)
                  2'b10: begin
                    st <= S_RD;
                    rd_adr <= adr_nx;
                    rd_bit <= '0;
                    rd_dummy <= 1'b1;
                  end
                  2'b01: begin
                    st <= S_DAT;
                    wral <= 1'b0;
                  end
                  2'b11: if (wen) pend <= P_ER;
                  default:
                    case (sub_nx)
                      2'b00: wen <= 1'b0;
                      2'b11: wen <= 1'b1;
                      2'b01: begin
                        st <= S_DAT;
                        wral <= 1'b1;
                      end
                      default: if (wen) pend <= P_ERAL;
                    endcase
                endcase
              end
            end
          S_DAT:
            if (sk_rise) begin
              dat <= {dat[14:0], di};
              cnt <= cnt + CW'(1);
              if (dat_last) begin
                st <= S_HOLD;
                if (wen) pend <= wral ? P_WRAL : P_WR;
              end
            end
          S_RD:
            if (sk_rise) begin
              if (rd_dummy) begin
                rd_dummy <= 1'b0;
              end else if (rd_bit == (org_x16 ? 4'd15 : 4'd7)) begin
                rd_bit <= '0;
                rd_adr <= org_x16 ? {1'b0, rd_lo_inc} : rd_adr + (AW+1)'(1);
              end else begin
                rd_bit <= rd_bit + 4'd1;
              end
            end
          default: ;
        endcase
      end
    end
  end

  // R11
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> st == S_IDLE);

  // R8
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_IDLE) |=> st == S_IDLE);

  // R7
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  // R9
  stat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_arm) |-> $past(sk_fall));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && cs && !sk_rise) |=> ($stable(rd_bit) && $stable(rd_adr)));

  // R4
  rd_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st == S_RD) && cs) |-> (do_oe && !do_o));

endmodule

// File: tb/tb_uwire_eeprom.sv
module tb_uwire_eeprom;
  localparam int AW = 4;
  localparam int BUSY = 20;
  localparam int NB = 2 ** (AW + 1);

  logic clk = 1'b0, rst_n = 1'b0, org_x16 = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int checks = 0, fails = 0;
  logic [7:0] bm [NB];

  always #4 clk = ~clk;

  uwire_eeprom #(.AW(AW), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  function automatic logic [15:0] expw(int a);
    if (org_x16) return {bm[(2 * a + 1) % NB], bm[(2 * a) % NB]};
    return {8'h00, bm[a % NB]};
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'(a * 4951) ^ 16'hA5C3;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    di = b; tick(2); sk = 1'b1; tick(4); sk = 1'b0; tick(2);
  endtask

  task automatic sk_rd(output logic b, output logic oe);
    di = 1'b0; tick(2); sk = 1'b1; tick(3); b = do_o; oe = do_oe; tick(1); sk = 1'b0; tick(2);
  endtask

  task automatic sel();
    cs = 1'b1; tick(2);
  endtask

  task automatic desel();
    cs = 1'b0; sk = 1'b0; di = 1'b0; tick(2);
  endtask

  function automatic int abits();
    return org_x16 ? AW : AW + 1;
  endfunction

  task automatic hdr(input logic [1:0] op, input int adr, input int lead);
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    sk_bit(1'b1); sk_bit(op[1]); sk_bit(op[0]);
    for (int i = abits() - 1; i >= 0; i--) sk_bit(adr[i]);
  endtask

  task automatic inst(input logic [1:0] op, input int adr, input int nd, input logic [15:0] d, input int lead);
    sel();
    hdr(op, adr, lead);
    for (int i = nd - 1; i >= 0; i--) sk_bit(d[i]);
    desel();
    tick(BUSY + 4);
  endtask

  task automatic spec(input int sub);
    inst(2'b00, sub << (abits() - 2), 0, 16'h0, 0);
  endtask

  task automatic model_wr(input int a, input logic [15:0] d);
    if (org_x16) begin
      bm[2 * a + 1] = d[15:8];
      bm[2 * a] = d[7:0];
    end else begin
      bm[a] = d[7:0];
    end
  endtask

  task automatic rd_check(input int a, input int n, input int lead, input string rq);
    logic b, oe;
    logic [15:0] got;
    int nw, wb;
    logic oe_ok;
    nw = 2 ** abits();
    wb = org_x16 ? 16 : 8;
    oe_ok = 1'b1;
    sel();
    hdr(2'b10, a, lead);
    chk({rq, " dummy"}, {do_oe, do_o}, 2'b10);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int j = 0; j < wb; j++) begin
        sk_rd(b, oe);
        got = {got[14:0], b};
        if (!oe) oe_ok = 1'b0;
      end
      chk(rq, got, expw((a + k) % nw));
    end
    chk({rq, " oe"}, oe_ok, 1'b1);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) bm[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R10 reset", do_oe, 1'b0);
    sel();
    chk("R10 idle", do_oe, 1'b0);
    desel();
    rd_check(0, 2, 0, "R6 reset");

    // R7: writing disabled after reset
    inst(2'b01, 3, 16, 16'h1234, 0);
    sel();
    chk("R7 no status", do_oe, 1'b0);
    desel();
    rd_check(3, 1, 0, "R7");

    spec(3);
    // R8: busy polling with exact timing
    sel();
    hdr(2'b01, 0, 0);
    for (int i = 15; i >= 0; i--) sk_bit(pat(0)[i]);
    cs = 1'b0; tick(2); cs = 1'b1; tick(1);
    chk("R8 busy", {do_oe, do_o}, 2'b10);
    tick(12);
    chk("R8 busy late", {do_oe, do_o}, 2'b10);
    tick(8);
    chk("R8 ready", {do_oe, do_o}, 2'b11);
    desel();
    model_wr(0, pat(0));

    for (int a = 1; a < 16; a++) begin
      inst(2'b01, a, 16, pat(a), a % 4);
      model_wr(a, pat(a));
    end
    rd_check(0, 17, 2, "R1 R4");

    // R3: byte view of the same storage
    org_x16 = 1'b0; tick(2);
    rd_check(0, 33, 0, "R3");
    inst(2'b01, 5, 8, 16'h003C, 1);
    model_wr(5, 16'h003C);
    rd_check(5, 1, 0, "R5");
    org_x16 = 1'b1; tick(2);
    rd_check(2, 1, 0, "R3 word");

    // R2 / R6: single erase
    inst(2'b11, 7, 0, 16'h0, 0);
    model_wr(7, 16'hFFFF);
    rd_check(6, 3, 0, "R2 R6");

    // R11: cut-short write
    sel();
    hdr(2'b01, 9, 0);
    for (int i = 0; i < 8; i++) sk_bit(1'b0);
    desel();
    sel();
    chk("R11 no status", do_oe, 1'b0);
    desel();
    rd_check(9, 1, 0, "R11");

    // R9: dummy one releases status on falling sk
    sel();
    hdr(2'b01, 10, 0);
    for (int i = 15; i >= 0; i--) sk_bit(16'hC0DE >> i);
    cs = 1'b0; tick(2); cs = 1'b1; tick(1);
    chk("R8 status", {do_oe, do_o}, 2'b10);
    di = 1'b1; tick(2); sk = 1'b1; tick(3);
    chk("R9 held", do_oe, 1'b1);
    tick(1); sk = 1'b0; tick(2);
    chk("R9 released", do_oe, 1'b0);
    desel();
    tick(BUSY);
    model_wr(10, 16'hC0DE);
    sel();
    chk("R9 stays off", do_oe, 1'b0);
    desel();
    rd_check(10, 1, 0, "R5 R9");

    // R7: disable blocks erase and write
    spec(0);
    inst(2'b11, 0, 0, 16'h0, 0);
    inst(2'b01, 1, 16, 16'h0000, 0);
    rd_check(0, 2, 0, "R7 disabled");

    // R6: write-all then erase-all
    spec(3);
    inst(2'b00, 1 << (AW - 2), 16, 16'h5A0F, 0);
    for (int a = 0; a < 16; a++) model_wr(a, 16'h5A0F);
    rd_check(0, 16, 0, "R2 R6 wral");
    inst(2'b00, 2 << (AW - 2), 0, 16'h0, 0);
    for (int i = 0; i < NB; i++) bm[i] = 8'hFF;
    rd_check(0, 16, 0, "R6 eral");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule